// File: doc/BRIEF.md
# Converter Sample Fetch SPI Master

This block reads results from an external two-channel converter that signals each finished conversion by pulling an active-low ready line low. The block never waits for software. Each falling edge of that line, once synchronized to the system clock, starts one SPI read. The block is the SPI master: it drives the serial clock and the chip select, and it shifts in 48 bits, 24 per channel. The whole frame fits in a few microseconds, well inside the roughly 15 µs between conversions at 65536 Hz.

Each completed frame is presented as two channel words on a valid/ready output. A 16-bit frame number travels with the words. The block either delivers every frame or reports that one was lost. A sticky overrun flag is set when a new ready edge arrives while a read is still running. It is also set when an edge arrives, or a frame completes, while the previous result has not yet been taken. A result that is not taken is never overwritten. A frame that cannot be delivered is dropped, and it still advances the frame number, so the consumer sees a gap.

The serial clock half-period is a run-time input, counted in system clock cycles.

Top module: `sample_fetch_spi`

## Requirements
- R1: After reset: `spi_cs_n` = 1, `spi_sclk` = 0, `out_valid` = 0, `overrun` = 0 and `out_count` = 0.
- R2: `conv_ready_n` passes through a two-flop synchronizer. Each falling edge seen while the block is idle starts exactly one frame: one low pulse of `spi_cs_n` containing 48 rising edges of `spi_sclk`. Holding the line low starts no further frames.
- R3: `spi_sclk` idles low. Every high phase and every low phase lasts `sclk_half` system clock cycles. A value of 0 behaves as 1.
- R4: `spi_miso` is sampled as `spi_sclk` rises, most significant bit first. The first 24 bits form `out_ch0` and the next 24 bits form `out_ch1`.
- R5: `spi_cs_n` goes low `sclk_half` cycles before the first rising edge of `spi_sclk`. It goes high `sclk_half` cycles after the last falling edge. `spi_sclk` is high only while `spi_cs_n` is low.
- R6: A presented result keeps `out_valid` = 1 and holds `out_ch0`, `out_ch1` and `out_count` stable until a clock edge where `out_ready` = 1. After that edge `out_valid` drops, unless a new frame is loaded at that same edge.
- R7: A frame counter advances on every completed frame, dropped ones included. `out_count` shows the counter value belonging to the presented frame, so the first frame after reset shows 1.
- R8: A falling edge that arrives during a frame neither restarts nor aborts it. The running frame completes with its own data, and `overrun` is set.
- R9: A falling edge that arrives while `out_valid` = 1 and `out_ready` = 0 still runs a frame and sets `overrun`. If the old result is still untaken when that frame completes, the old result stays presented and the new frame is dropped, leaving a gap in `out_count`.
- R10: `overrun` stays at 1 until a cycle with `ovr_clear` = 1. A new overrun event in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_ready_n | input | 1 | Converter result-ready line, asynchronous, active low |
| sclk_half | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| spi_sclk | output | 1 | Serial clock to the converter |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data from the converter |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_ch0 | output | CHAN_W | First channel word of the frame |
| out_ch1 | output | CHAN_W | Second channel word of the frame |
| out_count | output | CNT_W | Frame number of the presented result |
| overrun | output | 1 | Sticky lost-frame flag |
| ovr_clear | input | 1 | Clears `overrun` |

## Verification
The bench builds the block with its defaults: 24-bit channels, an 8-bit divider input and a 16-bit frame counter. At run time it drives half-periods of 1, 3 and 0. These values exercise the single-cycle phases, multi-cycle phases and the zero clamp, and the bench measures the select lead, the high phase and the select trail against each value. With a 48-bit frame, edges during a read, results left untaken and the counter gap can all be reached within a few hundred cycles per frame. Counter wrap lies beyond the run.

// File: rtl/sample_fetch_spi_pkg.sv
package sample_fetch_spi_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_TRAIL = 2'd3
  } spi_phase_t;

endpackage

// File: rtl/ready_fall_sync.sv
module ready_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic fall
);

  // chain[0..STAGES-1] synchronizer, chain[STAGES] previous synced value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], async_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import sample_fetch_spi_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DIV_W-1:0]   half,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);

  localparam int BIT_W = $clog2(FRAME_W + 1);

  spi_phase_t         phase;
  logic [DIV_W-1:0]   cnt;
  logic [DIV_W:0]     cnt_nx;
  logic               term;
  logic [BIT_W-1:0]   bits;
  logic [FRAME_W-1:0] shreg;

  // a half-period of 0 ends on the first count, same as 1
  assign cnt_nx = {1'b0, cnt} + 1'b1;
  assign term   = cnt_nx >= {1'b0, half};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      bits  <= '0;
      shreg <= '0;
      sclk  <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          cnt  <= '0;
          bits <= '0;
          if (start) begin
            cs_n  <= 1'b0;
            phase <= PH_LOW;
          end
        end
        PH_LOW: begin
          if (term) begin
            cnt   <= '0;
            sclk  <= 1'b1;
            shreg <= {shreg[FRAME_W-2:0], miso};
            bits  <= bits + 1'b1;
            phase <= PH_HIGH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (term) begin
            cnt   <= '0;
            sclk  <= 1'b0;
            phase <= (bits == BIT_W'(FRAME_W)) ? PH_TRAIL : PH_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TRAIL: begin
          if (term) begin
            cnt   <= '0;
            cs_n  <= 1'b1;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy  = (phase != PH_IDLE);
  assign frame = shreg;

endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int FRAME_W = 48,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  logic [FRAME_W-1:0] frame,
  input  logic               edge_fall,
  input  logic               busy,
  input  logic               out_ready,
  input  logic               ovr_clear,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame,
  output logic [CNT_W-1:0]   out_count,
  output logic               overrun
);

  logic [CNT_W-1:0] frame_cnt;
  logic             stall;
  logic             take;
  logic             ovr_set;

  assign stall   = out_valid & ~out_ready;
  assign take    = out_valid & out_ready;
  assign ovr_set = (edge_fall & busy) | (edge_fall & stall) | (done & stall);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      out_valid <= 1'b0;
      out_frame <= '0;
      out_count <= '0;
      overrun   <= 1'b0;
    end else begin
      if (done) frame_cnt <= frame_cnt + 1'b1;

      if (done && !stall) begin
        out_valid <= 1'b1;
        out_frame <= frame;
        out_count <= frame_cnt + 1'b1;
      end else if (take) begin
        out_valid <= 1'b0;
      end

      if (ovr_set)        overrun <= 1'b1;
      else if (ovr_clear) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/sample_fetch_spi.sv
module sample_fetch_spi #(
  parameter int CHAN_W      = 24,
  parameter int DIV_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_ready_n,
  input  logic [DIV_W-1:0]  sclk_half,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  input  logic              spi_miso,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAN_W-1:0] out_ch0,
  output logic [CHAN_W-1:0] out_ch1,
  output logic [CNT_W-1:0]  out_count,
  output logic              overrun,
  input  logic              ovr_clear
);

  localparam int NUM_CHAN = 2;
  localparam int FRAME_W  = NUM_CHAN * CHAN_W;

  logic               fall;
  logic               busy;
  logic               done;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] held;

  ready_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (conv_ready_n),
    .fall    (fall)
  );

  spi_frame_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) u_engine (
    .clk   (clk),
    .rst   (rst),
    .start (fall & ~busy),
    .half  (sclk_half),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .cs_n  (spi_cs_n),
    .busy  (busy),
    .done  (done),
    .frame (frame)
  );

  result_stage #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_result (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .frame     (frame),
    .edge_fall (fall),
    .busy      (busy),
    .out_ready (out_ready),
    .ovr_clear (ovr_clear),
    .out_valid (out_valid),
    .out_frame (held),
    .out_count (out_count),
    .overrun   (overrun)
  );

  // channel 0 arrives first, so it sits in the upper bits
  assign out_ch0 = held[FRAME_W-1:CHAN_W];
  assign out_ch1 = held[CHAN_W-1:0];

endmodule

// File: rtl/sample_fetch_spi_chk.sv
module sample_fetch_spi_chk #(
  parameter int CHAN_W = 24,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAN_W-1:0] out_ch0,
  input logic [CHAN_W-1:0] out_ch1,
  input logic [CNT_W-1:0]  out_count,
  input logic              overrun,
  input logic              ovr_clear
);

  // R5
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n);

  // R5
  cs_lead_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !spi_sclk);

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ch0) &&
                                   $stable(out_ch1) && $stable(out_count)));

  // R7
  count_moves_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_count != $past(out_count)));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clear) |=> overrun);

endmodule

bind sample_fetch_spi sample_fetch_spi_chk #(.CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sample_fetch_spi_bench.sv
module sample_fetch_spi_bench;

  localparam int CHAN_W = 24;
  localparam int DIV_W  = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              conv_ready_n = 1'b1;
  logic [DIV_W-1:0]  sclk_half = 8'd1;
  logic              spi_sclk, spi_cs_n;
  logic              spi_miso = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [CHAN_W-1:0] out_ch0, out_ch1;
  logic [CNT_W-1:0]  out_count;
  logic              overrun;
  logic              ovr_clear = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sample_fetch_spi #(.CHAN_W(CHAN_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_sample_fetch_spi (
    .clk(clk), .rst(rst), .conv_ready_n(conv_ready_n), .sclk_half(sclk_half),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .out_valid(out_valid), .out_ready(out_ready), .out_ch0(out_ch0), .out_ch1(out_ch1),
    .out_count(out_count), .overrun(overrun), .ovr_clear(ovr_clear)
  );

  // converter model: first bit on select fall, next bit on each clock fall
  logic [47:0] slave_word = '0;
  int idx = -1;
  always @(negedge spi_cs_n) begin
    spi_miso = slave_word[47];
    idx = 46;
  end
  always @(negedge spi_sclk) begin
    if (!spi_cs_n && idx >= 0) begin
      spi_miso = slave_word[idx];
      idx = idx - 1;
    end
  end

  // line monitor, sampled away from the active edge
  int rises, cs_falls, lead, trail, hi_run, hi_min, hi_max;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) cs_falls++;
    if (!spi_cs_n) begin
      if (rises == 0 && !spi_sclk) lead++;
      if (rises == 48 && !spi_sclk) trail++;
    end
    if (spi_sclk && !prev_sclk) begin rises++; hi_run = 0; end
    if (spi_sclk) hi_run++;
    if (!spi_sclk && prev_sclk) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
    end
    prev_sclk = spi_sclk;
    prev_cs = spi_cs_n;
  end

  task automatic reset_stats();
    rises = 0; cs_falls = 0; lead = 0; trail = 0; hi_run = 0; hi_min = 1000; hi_max = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_ready(input int low_len);
    @(negedge clk) conv_ready_n = 1'b0;
    repeat (low_len) @(negedge clk);
    conv_ready_n = 1'b1;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1; break; end
    end
  endtask

  task automatic wait_frame_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rises == 48 && spi_cs_n) break;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk) out_ready = 1'b1;
    @(negedge clk) out_ready = 1'b0;
    chk(out_valid == 1'b0, "R6 valid drops after take", 64'(out_valid), 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs idle", 64'(spi_cs_n), 1);
    chk(spi_sclk == 1'b0, "R1 sclk idle", 64'(spi_sclk), 0);
    chk(out_valid == 1'b0, "R1 valid", 64'(out_valid), 0);
    chk(overrun == 1'b0, "R1 overrun", 64'(overrun), 0);
    chk(out_count == '0, "R1 count", 64'(out_count), 0);
  endtask

  // one frame with timing checks; expected phase length is max(half,1)
  task automatic test_frame(input logic [47:0] w, input logic [7:0] half,
                            input int low_len, input logic [15:0] exp_cnt);
    bit got;
    int ph;
    ph = (half == 0) ? 1 : int'(half);
    sclk_half = half;
    slave_word = w;
    reset_stats();
    pulse_ready(low_len);
    wait_valid(got);
    chk(got, "R2 frame produced result", 64'(got), 1);
    chk(out_ch0 == w[47:24], "R4 channel 0 word", 64'(out_ch0), 64'(w[47:24]));
    chk(out_ch1 == w[23:0], "R4 channel 1 word", 64'(out_ch1), 64'(w[23:0]));
    chk(out_count == exp_cnt, "R7 frame number", 64'(out_count), 64'(exp_cnt));
    chk(rises == 48, "R2 rising edges per frame", 64'(rises), 48);
    chk(hi_min == ph && hi_max == ph, "R3 high phase length", 64'(hi_max), 64'(ph));
    chk(lead == ph, "R5 select lead", 64'(lead), 64'(ph));
    chk(trail == ph, "R5 select trail", 64'(trail), 64'(ph));
    repeat (20) @(negedge clk);
    chk(cs_falls == 1, "R2 one frame per edge", 64'(cs_falls), 1);
    take();
  endtask

  task automatic test_edge_in_frame();
    bit got;
    sclk_half = 8'd1;
    slave_word = 48'h0F0F0F_F0F0F0;
    reset_stats();
    pulse_ready(4);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rises >= 10) break;
    end
    pulse_ready(4);
    wait_valid(got);
    chk(out_ch0 == 24'h0F0F0F && out_ch1 == 24'hF0F0F0, "R8 frame kept its data",
        64'({out_ch0, out_ch1}), 64'h0F0F0FF0F0F0);
    chk(overrun == 1'b1, "R8 overrun on edge during frame", 64'(overrun), 1);
    chk(out_count == 16'd4, "R8 frame number", 64'(out_count), 4);
    repeat (300) @(negedge clk);
    chk(cs_falls == 1, "R8 no restart", 64'(cs_falls), 1);
    chk(overrun == 1'b1, "R10 overrun sticky", 64'(overrun), 1);
    take();
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    chk(overrun == 1'b0, "R10 clear", 64'(overrun), 0);
  endtask

  task automatic test_untaken();
    bit got;
    logic [23:0] c0, c1;
    logic [15:0] n;
    sclk_half = 8'd1;
    slave_word = 48'h111111_222222;
    reset_stats();
    pulse_ready(4);
    wait_valid(got);
    c0 = out_ch0; c1 = out_ch1; n = out_count;
    chk(n == 16'd5, "R7 frame number before drop", 64'(n), 5);
    repeat (50) @(negedge clk);
    chk(out_valid && out_ch0 == c0 && out_ch1 == c1 && out_count == n,
        "R6 result held while not taken", 64'(out_ch0), 64'(c0));
    slave_word = 48'h333333_444444;
    reset_stats();
    pulse_ready(4);
    wait_frame_end();
    chk(rises == 48, "R9 new frame still read", 64'(rises), 48);
    chk(out_ch0 == 24'h111111 && out_ch1 == 24'h222222, "R9 old result kept",
        64'({out_ch0, out_ch1}), 64'h111111222222);
    chk(out_count == 16'd5, "R9 old frame number kept", 64'(out_count), 5);
    chk(overrun == 1'b1, "R9 overrun on untaken result", 64'(overrun), 1);
    take();
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
    chk(overrun == 1'b0, "R10 clear after drop", 64'(overrun), 0);
    slave_word = 48'h555555_666666;
    reset_stats();
    pulse_ready(4);
    wait_valid(got);
    chk(out_count == 16'd7, "R9 gap in frame number", 64'(out_count), 7);
    chk(out_ch1 == 24'h666666, "R4 data after gap", 64'(out_ch1), 64'h666666);
    take();
  endtask

  initial begin
    test_reset();
    test_frame(48'hA5C3F0_123456, 8'd1, 300, 16'd1);
    test_frame(48'h800001_7FFFFE, 8'd3, 4, 16'd2);
    test_frame(48'hFFFFFF_000000, 8'd0, 4, 16'd3);
    test_edge_in_frame();
    test_untaken();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule